// File: doc/BRIEF.md
# EDID Responder for I2C Tunnelled over an Auxiliary Channel

This block answers the register traffic a display driver produces when it fetches a monitor's EDID by tunnelling I2C over a display auxiliary channel. Software writes a request header into a data register, then writes the control register with the send bit set. The block decodes that request and completes it in the same clock edge. It updates a small I2C session state, overwrites the control register with a completion status, and places a reply word in the first data register. The reply word carries the I2C acknowledge code and, for a byte read, the next EDID byte.

Start, restart and stop are not sent as separate events. The block infers them from the message length and from the middle-of-transaction flag in the opcode. The EDID bytes come from outside the block: it drives the selected display port and a byte index, and it takes back the byte at that position in the same cycle. Per-port inputs say whether a display is attached and whether that display is DisplayPort. A read that cannot be served returns 0xFF.

The session state machine has three states:
- `I2C_IDLE`: no slave selected.
- `I2C_SEL_EMPTY`: the EDID slave is selected, but no DisplayPort display is attached to its port.
- `I2C_SEL_READY`: the EDID slave is selected and bytes can be read.

The transitions are:
- **stop**: from any state to `I2C_IDLE`, clearing the pointer.
- **null-address start**: from any state to `I2C_IDLE`, clearing the pointer.
- **EDID start**: from any state to `I2C_SEL_READY` or to `I2C_SEL_EMPTY`, depending on the attached display. The pointer is kept.
- **foreign start**: a start to any other address. The state stays as it is.
- **byte read**: stays in its state. In `I2C_SEL_READY` it advances the pointer.
- **write, short read, passive control write**: no transition.

Top module: `aux_edid_responder`

## Requirements
- R1: After reset, all six registers read 0, the session is idle, and `edid_index` and `edid_port` are 0.
- R2: Register slots are decoded from the low address byte. 0x10 is control, and 0x14, 0x18, 0x1C, 0x20 and 0x24 are data words 1 to 5. A write to a data slot is stored and reads back unchanged. Any other address reads 0, and writes to it are ignored.
- R3: A control write with bit 31 (send) clear changes nothing: not the control word, not data word 1, not the session state.
- R4: A control write with send set replaces the control word. The new word has bit 30 (done) set and a reply size in bits 24:20. The size is 2 when opcode bit 0 is 1 (read) and 1 otherwise. All other bits are 0.
- R5: The request is taken from data word 1 as it stands at the send. The target address is bits 23:8 and the opcode is bits 31:28. Opcode bit 0 selects read, and opcode bit 2 is the middle-of-transaction flag. The message length is control bits 24:20 of the send write.
- R6: Length 3 with the middle-of-transaction flag clear is a stop. The session goes idle and the byte pointer returns to 0.
- R7: Length 3 with the flag set is a start. Address 0 makes the session idle with pointer 0. Address 0x0050 selects the EDID slave and records `aux_port`. Bytes become available only if that port has `disp_present` and `disp_is_dp` both set. Any other address leaves the state unchanged.
- R8: A write opcode with a length other than 3 sets data word 1 to the acknowledge word and leaves the session untouched.
- R9: A read of length 4 puts a byte in data word 1 bits 23:16 and zero in bits 15:0. When bytes are available and the pointer is below the EDID size, the byte is the EDID byte at the pointer, and the pointer advances by one. When bytes are available and the pointer has reached the size, the byte is 0x00 and the pointer stays. When no slave is selected or no bytes are available, the byte is 0xFF.
- R10: A read with a length other than 3 or 4 leaves data word 1 and the pointer unchanged, but the control word still reports done.
- R11: Every stop, start, write or length-4 read writes the acknowledge code (default 0x00) into data word 1 bits 31:24.
- R12: A start to the EDID address while the slave is already selected keeps the byte pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Low address byte of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Low address byte of the read |
| rd_data | output | 32 | Register read data (combinational) |
| aux_port | input | PORT_W | Display port served by this channel |
| disp_present | input | NPORTS | Display attached, one bit per port |
| disp_is_dp | input | NPORTS | Attached display is DisplayPort, one bit per port |
| edid_port | output | PORT_W | Port whose EDID is being read |
| edid_index | output | IDX_W | Byte pointer into the EDID |
| edid_data | input | 8 | EDID byte at `edid_port`/`edid_index` |

## Verification
The hardest condition to reach is a pointer that has run to the end of the EDID. From the ports this needs a full selection followed by 128 back-to-back byte reads. The bench builds it with a loop of length-4 reads on a fresh DisplayPort selection, then issues one more read and expects 0x00 with the pointer held. The other awkward cases are the near-misses in decode: an address that differs from the EDID address only in bit 8 of the target field, a read with length 2, and a restart to the EDID address in the middle of a fetch. Each is placed between ordinary reads, so that a wrong pointer change shows up in the next byte returned.

// File: rtl/aux_edid_pkg.sv
package aux_edid_pkg;

    // control word fields
    localparam int SEND_BIT = 31;
    localparam int DONE_BIT = 30;
    localparam int LEN_LSB  = 20;
    localparam int LEN_W    = 5;

    // opcode bits inside the header
    localparam int OP_READ_BIT = 0;
    localparam int OP_MOT_BIT  = 2;

    // message lengths with a fixed meaning
    localparam logic [LEN_W-1:0] LEN_ADDR_ONLY = LEN_W'(3);
    localparam logic [LEN_W-1:0] LEN_ONE_BYTE  = LEN_W'(4);

    // register slots
    localparam int NSLOTS = 6;
    localparam int SLOT_W = 3;
    localparam logic [SLOT_W-1:0] SLOT_CTL  = 3'd0;
    localparam logic [SLOT_W-1:0] SLOT_HDR  = 3'd1;
    localparam logic [SLOT_W-1:0] SLOT_NONE = 3'd7;
    localparam logic [7:0] SLOT_BASE = 8'h10;

    typedef enum logic [1:0] {
        I2C_IDLE      = 2'd0,
        I2C_SEL_EMPTY = 2'd1,
        I2C_SEL_READY = 2'd2
    } i2c_state_e;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_STOP,
        CMD_START,
        CMD_WRITE,
        CMD_READ,
        CMD_READ_BADLEN
    } aux_cmd_e;

    typedef struct packed {
        aux_cmd_e    cmd;
        logic [15:0] target;
    } aux_req_t;

    // word-aligned addresses from SLOT_BASE upward map to consecutive slots
    function automatic logic [SLOT_W-1:0] slot_of(input logic [7:0] a);
        logic [7:0] off;
        off = a - SLOT_BASE;
        if (a >= SLOT_BASE && off[1:0] == 2'b00 && off[7:2] < 6'(NSLOTS))
            return off[2+SLOT_W-1:2];
        return SLOT_NONE;
    endfunction

endpackage

// File: rtl/aux_edid_decode.sv
module aux_edid_decode
    import aux_edid_pkg::*;
(
    input  logic             send,
    input  logic [31:0]      header,
    input  logic [LEN_W-1:0] msg_len,
    output aux_req_t         req,
    output logic             rd_op
);

    logic [3:0] opcode;

    assign opcode = header[31:28];
    assign rd_op  = opcode[OP_READ_BIT];

    always_comb begin
        req.target = header[23:8];
        req.cmd    = CMD_NONE;
        if (send) begin
            if (msg_len == LEN_ADDR_ONLY)
                req.cmd = opcode[OP_MOT_BIT] ? CMD_START : CMD_STOP;
            else if (!opcode[OP_READ_BIT])
                req.cmd = CMD_WRITE;
            else if (msg_len == LEN_ONE_BYTE)
                req.cmd = CMD_READ;
            else
                req.cmd = CMD_READ_BADLEN;
        end
    end

endmodule

// File: rtl/aux_edid_i2c_fsm.sv
module aux_edid_i2c_fsm
    import aux_edid_pkg::*;
#(
    parameter int          NPORTS    = 4,
    parameter int          EDID_SIZE = 128,
    parameter logic [15:0] EDID_ADDR = 16'h0050,
    parameter logic [7:0]  ACK_CODE  = 8'h00,
    localparam int         PORT_W    = $clog2(NPORTS),
    localparam int         IDX_W     = $clog2(EDID_SIZE + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  aux_req_t          req,
    input  logic [PORT_W-1:0] aux_port,
    input  logic [NPORTS-1:0] disp_present,
    input  logic [NPORTS-1:0] disp_is_dp,
    input  logic [7:0]        edid_data,
    output logic [PORT_W-1:0] edid_port,
    output logic [IDX_W-1:0]  edid_index,
    output logic              reply_en,
    output logic [31:0]       reply_word
);

    localparam logic [IDX_W-1:0] SIZE_L = IDX_W'(EDID_SIZE);

    i2c_state_e        state_q, state_n;
    logic [IDX_W-1:0]  ptr_q, ptr_n;
    logic [PORT_W-1:0] port_q, port_n;
    logic              port_has_dp;
    logic              have_byte;
    logic [7:0]        reply_byte;

    assign port_has_dp = disp_present[aux_port] & disp_is_dp[aux_port];
    assign have_byte   = (ptr_q < SIZE_L);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= I2C_IDLE;
            ptr_q   <= '0;
            port_q  <= '0;
        end else begin
            state_q <= state_n;
            ptr_q   <= ptr_n;
            port_q  <= port_n;
        end
    end

    // transitions
    always_comb begin
        state_n = state_q;
        ptr_n   = ptr_q;
        port_n  = port_q;
        unique case (req.cmd)
            CMD_STOP: begin
                state_n = I2C_IDLE;
                ptr_n   = '0;
            end
            CMD_START: begin
                if (req.target == 16'h0000) begin
                    state_n = I2C_IDLE;
                    ptr_n   = '0;
                end else if (req.target == EDID_ADDR) begin
                    port_n  = aux_port;
                    state_n = port_has_dp ? I2C_SEL_READY : I2C_SEL_EMPTY;
                end
            end
            CMD_READ: begin
                unique case (state_q)
                    I2C_SEL_READY: if (have_byte) ptr_n = ptr_q + IDX_W'(1);
                    default: ;
                endcase
            end
            default: ;
        endcase
    end

    // outputs
    always_comb begin
        reply_en   = 1'b0;
        reply_byte = 8'h00;
        unique case (req.cmd)
            CMD_STOP, CMD_START, CMD_WRITE: reply_en = 1'b1;
            CMD_READ: begin
                reply_en = 1'b1;
                unique case (state_q)
                    I2C_SEL_READY: reply_byte = have_byte ? edid_data : 8'h00;
                    default:       reply_byte = 8'hFF;
                endcase
            end
            default: ;
        endcase
        reply_word = {ACK_CODE, reply_byte, 16'h0000};
    end

    assign edid_port  = port_q;
    assign edid_index = ptr_q;

    assert_ptr_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= SIZE_L);

    assert_idle_ptr_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == I2C_IDLE) |-> (ptr_q == '0));

    assert_stop_idles_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req.cmd == CMD_STOP) |=> (state_q == I2C_IDLE && ptr_q == '0));

    assert_ptr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req.cmd == CMD_NONE || req.cmd == CMD_WRITE || req.cmd == CMD_READ_BADLEN)
        |=> $stable(ptr_q));

endmodule

// File: rtl/aux_edid_regs.sv
module aux_edid_regs
    import aux_edid_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [31:0]       wr_data,
    input  logic              send,
    input  logic [31:0]       ctl_update,
    input  logic              reply_en,
    input  logic [31:0]       reply_word,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [31:0]       rd_word,
    output logic [31:0]       header
);

    logic [NSLOTS-1:0][31:0] word;

    for (genvar g = 0; g < NSLOTS; g++) begin : g_slot
        logic [31:0] q;
        if (g == 0) begin : g_ctl
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)    q <= '0;
                else if (send) q <= ctl_update;
            end
        end else if (g == 1) begin : g_hdr
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                                q <= '0;
                else if (wr_en && wr_slot == SLOT_W'(g))   q <= wr_data;
                else if (send && reply_en)                 q <= reply_word;
            end
        end else begin : g_plain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                              q <= '0;
                else if (wr_en && wr_slot == SLOT_W'(g)) q <= wr_data;
            end
        end
        assign word[g] = q;
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NSLOTS; i++)
            if (rd_slot == SLOT_W'(i)) rd_word = word[i];
    end

    assign header = word[1];

    assert_passive_ctl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_slot == SLOT_CTL && !wr_data[SEND_BIT])
        |=> ($stable(word[0]) && $stable(word[1])));

    assert_done_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        send |=> word[0][DONE_BIT]);

endmodule

// File: rtl/aux_edid_responder.sv
module aux_edid_responder
    import aux_edid_pkg::*;
#(
    parameter int          NPORTS    = 4,
    parameter int          EDID_SIZE = 128,
    parameter logic [15:0] EDID_ADDR = 16'h0050,
    parameter logic [7:0]  ACK_CODE  = 8'h00,
    localparam int         PORT_W    = $clog2(NPORTS),
    localparam int         IDX_W     = $clog2(EDID_SIZE + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [7:0]        rd_addr,
    output logic [31:0]       rd_data,
    input  logic [PORT_W-1:0] aux_port,
    input  logic [NPORTS-1:0] disp_present,
    input  logic [NPORTS-1:0] disp_is_dp,
    output logic [PORT_W-1:0] edid_port,
    output logic [IDX_W-1:0]  edid_index,
    input  logic [7:0]        edid_data
);

    logic [SLOT_W-1:0] wr_slot, rd_slot;
    logic              send;
    logic [31:0]       header;
    logic [31:0]       ctl_update;
    logic              rd_op;
    aux_req_t          req;
    logic              reply_en;
    logic [31:0]       reply_word;

    assign wr_slot = slot_of(wr_addr);
    assign rd_slot = slot_of(rd_addr);
    assign send    = wr_en && (wr_slot == SLOT_CTL) && wr_data[SEND_BIT];

    always_comb begin
        ctl_update                      = '0;
        ctl_update[DONE_BIT]            = 1'b1;
        ctl_update[LEN_LSB +: LEN_W]    = rd_op ? LEN_W'(2) : LEN_W'(1);
    end

    aux_edid_decode u_decode (
        .send    (send),
        .header  (header),
        .msg_len (wr_data[LEN_LSB +: LEN_W]),
        .req     (req),
        .rd_op   (rd_op)
    );

    aux_edid_i2c_fsm #(
        .NPORTS    (NPORTS),
        .EDID_SIZE (EDID_SIZE),
        .EDID_ADDR (EDID_ADDR),
        .ACK_CODE  (ACK_CODE)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req          (req),
        .aux_port     (aux_port),
        .disp_present (disp_present),
        .disp_is_dp   (disp_is_dp),
        .edid_data    (edid_data),
        .edid_port    (edid_port),
        .edid_index   (edid_index),
        .reply_en     (reply_en),
        .reply_word   (reply_word)
    );

    aux_edid_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_slot    (wr_slot),
        .wr_data    (wr_data),
        .send       (send),
        .ctl_update (ctl_update),
        .reply_en   (reply_en),
        .reply_word (reply_word),
        .rd_slot    (rd_slot),
        .rd_word    (rd_data),
        .header     (header)
    );

endmodule

// File: tb/aux_edid_responder_test.sv
module aux_edid_responder_test;

    localparam int PERIOD = 10;
    localparam int SZ     = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = 8'h00;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = 8'h10;
    logic [31:0] rd_data;
    logic [1:0]  aux_port = 2'd0;
    logic [3:0]  disp_present = 4'b1111;
    logic [3:0]  disp_is_dp   = 4'b1011;
    logic [1:0]  edid_port;
    logic [7:0]  edid_index;
    logic [7:0]  edid_data;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [31:0] m_reg [6];
    int m_state = 0;  // 0 idle, 1 selected-empty, 2 selected-ready
    int m_ptr   = 0;
    int m_port  = 0;

    function automatic logic [7:0] rom(input int p, input int i);
        return 8'((i * 7) + (p * 37) + 5);
    endfunction

    assign edid_data = rom(int'(edid_port), int'(edid_index));

    aux_edid_responder uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .aux_port(aux_port),
        .disp_present(disp_present), .disp_is_dp(disp_is_dp),
        .edid_port(edid_port), .edid_index(edid_index), .edid_data(edid_data)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int slot(input logic [7:0] a);
        if (a >= 8'h10 && a <= 8'h24 && a[1:0] == 2'b00) return (int'(a) - 16) / 4;
        return -1;
    endfunction

    function automatic logic [31:0] hdr(input logic [3:0] op, input logic [15:0] t);
        return {op, 4'h0, t, 8'h00};
    endfunction

    task automatic model_apply(input logic [7:0] a, input logic [31:0] d);
        int s;
        logic [31:0] h;
        logic [4:0]  len;
        logic [7:0]  b;
        s = slot(a);
        if (s < 0) return;
        if (s != 0) begin m_reg[s] = d; return; end
        if (!d[31]) return;
        len = d[24:20];
        h   = m_reg[1];
        m_reg[0] = 32'h4000_0000 | ((h[28] ? 32'd2 : 32'd1) << 20);
        if (len == 5'd3) begin
            if (!h[30]) begin m_state = 0; m_ptr = 0; end
            else if (h[23:8] == 16'h0000) begin m_state = 0; m_ptr = 0; end
            else if (h[23:8] == 16'h0050) begin
                m_port  = int'(aux_port);
                m_state = (disp_present[aux_port] && disp_is_dp[aux_port]) ? 2 : 1;
            end
            m_reg[1] = 32'h0;
        end else if (!h[28]) begin
            m_reg[1] = 32'h0;
        end else if (len == 5'd4) begin
            if (m_state == 2) begin
                if (m_ptr < SZ) begin b = rom(m_port, m_ptr); m_ptr++; end
                else b = 8'h00;
            end else b = 8'hFF;
            m_reg[1] = {8'h00, b, 16'h0000};
        end
    endtask

    // per-cycle comparison against the model
    always @(posedge clk) begin
        int s;
        #(PERIOD/4);
        if (rst_n) begin
            s = slot(rd_addr);
            check(rd_data, (s >= 0) ? m_reg[s] : 32'h0, "R2 per-cycle register view");
            check(32'(edid_index), 32'(m_ptr), "R9 per-cycle pointer");
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        model_apply(a, d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic send_ctl(input int len, input logic [31:0] h);
        wr(8'h14, h);
        wr(8'h10, 32'h8000_0000 | (32'(len) << 20));
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        rd_addr = a;
        #1;
        check(rd_data, exp, tag);
    endtask

    task automatic select_port(input logic [1:0] p);
        aux_port = p;
        send_ctl(3, hdr(4'h5, 16'h0050));
    endtask

    task automatic read1();
        send_ctl(4, hdr(4'h5, 16'h0050));
    endtask

    initial begin
        #(PERIOD * 200000);
        errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 6; i++) m_reg[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int i = 0; i < 6; i++) rd_chk(8'(8'h10 + 4 * i), 32'h0, "R1 register reset");
        check(32'(edid_index), 0, "R1 pointer reset");
        check(32'(edid_port), 0, "R1 port reset");

        // R2 map and plain storage
        wr(8'h18, 32'hA1A2_A3A4);
        wr(8'h1C, 32'hB1B2_B3B4);
        wr(8'h20, 32'hC1C2_C3C4);
        wr(8'h24, 32'hD1D2_D3D4);
        wr(8'h28, 32'hDEAD_BEEF);
        wr(8'h12, 32'hFFFF_FFFF);
        rd_chk(8'h18, 32'hA1A2_A3A4, "R2 data word 2");
        rd_chk(8'h1C, 32'hB1B2_B3B4, "R2 data word 3");
        rd_chk(8'h20, 32'hC1C2_C3C4, "R2 data word 4");
        rd_chk(8'h24, 32'hD1D2_D3D4, "R2 data word 5");
        rd_chk(8'h28, 32'h0, "R2 unmapped address");
        rd_chk(8'h10, 32'h0, "R2 misaligned write ignored");

        // R7 select DisplayPort display on port 1
        select_port(2'd1);
        rd_chk(8'h10, 32'h4020_0000, "R4 done and size 2 for read opcode");
        rd_chk(8'h14, 32'h0, "R11 start reply acknowledge");
        check(32'(edid_port), 1, "R7 port recorded");

        // R9 byte reads
        for (int k = 0; k < 3; k++) begin
            read1();
            rd_chk(8'h14, {8'h00, rom(1, k), 16'h0}, "R9 EDID byte");
            check(32'(edid_index), 32'(k + 1), "R9 pointer advance");
        end

        // R3 passive control write
        wr(8'h10, 32'h0040_0000);
        rd_chk(8'h10, 32'h4020_0000, "R3 control kept");
        rd_chk(8'h14, {8'h00, rom(1, 2), 16'h0}, "R3 data word 1 kept");
        check(32'(edid_index), 3, "R3 pointer kept");

        // R10 read with length 2
        send_ctl(2, hdr(4'h5, 16'h0050));
        rd_chk(8'h14, 32'h5000_5000, "R10 header untouched");
        rd_chk(8'h10, 32'h4020_0000, "R10 done reported");
        check(32'(edid_index), 3, "R10 pointer kept");

        // R8 write opcode
        send_ctl(4, hdr(4'h4, 16'h0050));
        rd_chk(8'h14, 32'h0, "R8 write acknowledged");
        rd_chk(8'h10, 32'h4010_0000, "R4 size 1 for write opcode");
        check(32'(edid_index), 3, "R8 pointer kept");

        // R12 restart keeps pointer
        select_port(2'd1);
        check(32'(edid_index), 3, "R12 restart keeps pointer");
        read1();
        rd_chk(8'h14, {8'h00, rom(1, 3), 16'h0}, "R12 continues after restart");

        // R7 start to a foreign address changes nothing
        send_ctl(3, hdr(4'h5, 16'h0037));
        read1();
        rd_chk(8'h14, {8'h00, rom(1, 4), 16'h0}, "R7 foreign start ignored");

        // R6 stop
        send_ctl(3, hdr(4'h1, 16'h0050));
        check(32'(edid_index), 0, "R6 stop clears pointer");
        read1();
        rd_chk(8'h14, 32'h00FF_0000, "R9 idle read returns FF");

        // R5 address field: bit 8 of target differs
        send_ctl(3, hdr(4'h5, 16'h0150));
        read1();
        rd_chk(8'h14, 32'h00FF_0000, "R5 target field decode");

        // R7 null address resets
        select_port(2'd1);
        read1();
        send_ctl(3, hdr(4'h5, 16'h0000));
        check(32'(edid_index), 0, "R7 null address resets");
        read1();
        rd_chk(8'h14, 32'h00FF_0000, "R7 idle after null address");

        // R7 non-DisplayPort display
        select_port(2'd2);
        check(32'(edid_port), 2, "R7 port recorded for non-DP");
        read1();
        rd_chk(8'h14, 32'h00FF_0000, "R7 non-DP gives no bytes");
        check(32'(edid_index), 0, "R7 non-DP pointer kept");

        // R9 run to the end of the EDID
        select_port(2'd3);
        for (int k = 0; k < SZ; k++) read1();
        rd_chk(8'h14, {8'h00, rom(3, SZ - 1), 16'h0}, "R9 last EDID byte");
        check(32'(edid_index), 32'(SZ), "R9 pointer at size");
        read1();
        rd_chk(8'h14, 32'h0000_0000, "R9 past end returns 00");
        check(32'(edid_index), 32'(SZ), "R9 pointer held at size");

        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule